// File: doc/BRIEF.md
# Clock Alarm Output Combiner

This block turns the raw outputs of the clock input monitors into alarm pins for a configuration where inputs 3 and 4 carry frame-sync signals instead of clocks. Two primary alarm pins report loss of signal on clock inputs 1 and 2. Loss of signal on the matching frame-sync input is added to each pin when the frame-sync switch bit is set. Frequency-offset alarms are added only when frequency-offset reporting is enabled. A third alarm pin stays released in this mode. A shared pin carries either the frame alignment alarm or the interrupt.

Each pin is presented as a value and an output enable, for a pad cell to use. One configuration bit sets the active level of every pin. The raw monitor bits are also sent to a status output with no change. Sticky copies of the six monitor bits are kept. Software clears them by writing ones. The sticky bits that are not masked are ORed together to form a registered interrupt.

Top module: `clk_alarm_combiner`

## Requirements
- R1: When driven, alarm pin 1 shows, at its active level, `los_raw[0] | (los_raw[2] & fsync_sw) | (fos_en & fos_raw[0])` in the same cycle as its inputs.
- R2: When driven, alarm pin 2 shows, at its active level, `los_raw[1] | (los_raw[3] & fsync_sw) | (fos_en & fos_raw[1])` in the same cycle as its inputs.
- R3: Alarm pin 3 is never driven (`alm3_oe` = 0, `alm3_o` = 0). With `irq_sel` = 0, the shared pin carries `align_alarm`.
- R4: Pin enables are mapped as bit 0 = pin 1, bit 1 = pin 2 and bit 3 = shared pin (bit 2 has no effect). Each output enable equals its enable bit, except as stated in R5. An undriven pin outputs 0.
- R5: With `irq_sel` = 1, the shared pin is always driven and carries the registered interrupt, whatever the value of `pin_en[3]`.
- R6: `alarm_pol` = 1 makes every driven pin active high. `alarm_pol` = 0 inverts every driven pin value.
- R7: `status_raw` = `{fos_raw, los_raw}` in the same cycle, whatever the masks, enables and flags hold.
- R8: Flag bit i (order as in R7) is set at the clock edge at which raw bit i is 1 and was 0 at the previous edge. The sample taken before the first edge after reset counts as 0.
- R9: A set flag stays set until an edge with `clr_wr` = 1 and `clr_data[i]` = 1. If a set and a clear fall on the same edge, the set wins.
- R10: `flag_mask[i]` = 1 stops flag i from reaching the interrupt. The flag itself still sets and holds.
- R11: `irq_o` is the OR of (`flags` & ~`flag_mask`) as sampled at the previous clock edge. After reset, `flags` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| los_raw | input | 4 | Raw loss-of-signal bits, inputs 1..4 |
| fos_raw | input | 2 | Raw frequency-offset bits, inputs 1..2 |
| fsync_sw | input | 1 | Adds frame-sync loss to the primary pins |
| align_alarm | input | 1 | Frame alignment alarm |
| fos_en | input | 1 | Enables frequency-offset reporting on the pins |
| alarm_pol | input | 1 | 1 = active-high pins, 0 = active-low |
| pin_en | input | 4 | Per-pin drive enables |
| irq_sel | input | 1 | Interrupt replaces the shared pin |
| flag_mask | input | 6 | Per-flag interrupt mask, 1 = masked |
| clr_wr | input | 1 | Write strobe for flag clearing |
| clr_data | input | 6 | Write-one-to-clear flag bits |
| status_raw | output | 6 | Raw monitor bits |
| flags | output | 6 | Sticky flags |
| irq_o | output | 1 | Registered interrupt, active high |
| alm1_o | output | 1 | Alarm pin 1 value |
| alm1_oe | output | 1 | Alarm pin 1 enable |
| alm2_o | output | 1 | Alarm pin 2 value |
| alm2_oe | output | 1 | Alarm pin 2 enable |
| alm3_o | output | 1 | Alarm pin 3 value |
| alm3_oe | output | 1 | Alarm pin 3 enable |
| shr_o | output | 1 | Shared pin value |
| shr_oe | output | 1 | Shared pin enable |

## Verification
The pin values, the enables and `status_raw` are combinational and must follow their inputs in the same cycle. The flags change one edge after the qualifying sample, and `irq_o` changes one edge after the flags, which is two edges after a raw rise. The bench applies stimulus at the falling edge and compares all outputs shortly after it. Its reference model advances the flag state and the interrupt state once per rising edge, so each expected value falls in the correct cycle.

// File: rtl/clk_alarm_combiner.sv
module clk_alarm_combiner (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] los_raw,
  input  logic [1:0] fos_raw,
  input  logic       fsync_sw,
  input  logic       align_alarm,
  input  logic       fos_en,
  input  logic       alarm_pol,
  input  logic [3:0] pin_en,
  input  logic       irq_sel,
  input  logic [5:0] flag_mask,
  input  logic       clr_wr,
  input  logic [5:0] clr_data,
  output logic [5:0] status_raw,
  output logic [5:0] flags,
  output logic       irq_o,
  output logic       alm1_o,
  output logic       alm1_oe,
  output logic       alm2_o,
  output logic       alm2_oe,
  output logic       alm3_o,
  output logic       alm3_oe,
  output logic       shr_o,
  output logic       shr_oe
);
  logic [5:0] raw, prev_q, flag_q, clr_m;
  logic       irq_q, a1, a2, shr_a, inv;

  assign raw        = {fos_raw, los_raw};
  assign status_raw = raw;
  assign flags      = flag_q;
  assign irq_o      = irq_q;
  assign inv        = ~alarm_pol;

  assign a1    = los_raw[0] | (los_raw[2] & fsync_sw) | (fos_en & fos_raw[0]);
  assign a2    = los_raw[1] | (los_raw[3] & fsync_sw) | (fos_en & fos_raw[1]);
  assign shr_a = irq_sel ? irq_q : align_alarm;

  assign alm1_oe = pin_en[0];
  assign alm1_o  = pin_en[0] & (a1 ^ inv);
  assign alm2_oe = pin_en[1];
  assign alm2_o  = pin_en[1] & (a2 ^ inv);
  assign alm3_oe = 1'b0;
  assign alm3_o  = 1'b0;
  assign shr_oe  = irq_sel | pin_en[3];
  assign shr_o   = shr_oe & (shr_a ^ inv);

  assign clr_m = clr_wr ? clr_data : 6'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= raw;
      flag_q <= (flag_q & ~clr_m) | (raw & ~prev_q);
      irq_q  <= |(flag_q & ~flag_mask);
    end
  end
endmodule

// File: rtl/clk_alarm_combiner_chk.sv
module clk_alarm_combiner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] status_raw,
  input logic [5:0] flags,
  input logic [5:0] flag_mask,
  input logic       clr_wr,
  input logic [5:0] clr_data,
  input logic       irq_o,
  input logic       irq_sel,
  input logic [3:0] pin_en,
  input logic       alm1_oe,
  input logic       alm2_oe,
  input logic       alm3_o,
  input logic       alm3_oe,
  input logic       shr_oe
);
  a_r3_pin3_released: assert property (@(posedge clk) disable iff (!rst_n)
    !alm3_oe && !alm3_o);

  a_r4_pin1_enable: assert property (@(posedge clk) disable iff (!rst_n)
    alm1_oe == pin_en[0]);

  a_r4_pin2_enable: assert property (@(posedge clk) disable iff (!rst_n)
    alm2_oe == pin_en[1]);

  a_r5_irq_takes_pin: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sel |-> shr_oe);

  a_r11_irq_timing: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(flags) & ~$past(flag_mask))));

  for (genvar i = 0; i < 6; i++) begin : g_flag
    a_r8_set_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_raw[i]) |=> flags[i]);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !(clr_wr && clr_data[i])) |=> flags[i]);
  end
endmodule

bind clk_alarm_combiner clk_alarm_combiner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status_raw(status_raw), .flags(flags),
  .flag_mask(flag_mask), .clr_wr(clr_wr), .clr_data(clr_data),
  .irq_o(irq_o), .irq_sel(irq_sel), .pin_en(pin_en),
  .alm1_oe(alm1_oe), .alm2_oe(alm2_oe), .alm3_o(alm3_o),
  .alm3_oe(alm3_oe), .shr_oe(shr_oe)
);

// File: tb/clk_alarm_combiner_tb.sv
module clk_alarm_combiner_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] los_raw, pin_en;
  logic [1:0] fos_raw;
  logic fsync_sw, align_alarm, fos_en, alarm_pol, irq_sel, clr_wr;
  logic [5:0] flag_mask, clr_data, status_raw, flags;
  logic irq_o, alm1_o, alm1_oe, alm2_o, alm2_oe, alm3_o, alm3_oe, shr_o, shr_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [5:0] m_flag, m_prev;
  logic m_irq;

  always #4 clk = ~clk;

  clk_alarm_combiner u_dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic pinv(input logic a, input logic en);
    return en & (alarm_pol ? a : ~a);
  endfunction

  task automatic check_all();
    logic e1, e2, es;
    e1 = los_raw[0] | (los_raw[2] & fsync_sw) | (fos_en & fos_raw[0]);
    e2 = los_raw[1] | (los_raw[3] & fsync_sw) | (fos_en & fos_raw[1]);
    es = irq_sel ? m_irq : align_alarm;
    chk("R1 pin1", {alm1_oe, alm1_o}, {pin_en[0], pinv(e1, pin_en[0])});
    chk("R2 pin2", {alm2_oe, alm2_o}, {pin_en[1], pinv(e2, pin_en[1])});
    chk("R3 pin3", {alm3_oe, alm3_o}, 8'd0);
    chk("R4/R5/R6 shared", {shr_oe, shr_o},
        {irq_sel | pin_en[3], pinv(es, irq_sel | pin_en[3])});
    chk("R7 status", status_raw, {fos_raw, los_raw});
    chk("R8/R9/R10 flags", flags, m_flag);
    chk("R11 irq", irq_o, m_irq);
  endtask

  task automatic step();
    logic [5:0] raw, cm;
    raw = {fos_raw, los_raw};
    cm = clr_wr ? clr_data : 6'd0;
    m_irq  = |(m_flag & ~flag_mask);
    m_flag = (m_flag & ~cm) | (raw & ~m_prev);
    m_prev = raw;
  endtask

  task automatic cycle();
    #1 check_all();
    step();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; los_raw = 4'hF; fos_raw = 2'h3; fsync_sw = 0; align_alarm = 1;
    fos_en = 0; alarm_pol = 1; pin_en = 4'hF; irq_sel = 0; flag_mask = 0;
    clr_wr = 0; clr_data = 0;
    m_flag = 0; m_prev = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset flags", flags, 8'd0);
    chk("R11 reset irq", irq_o, 8'd0);
    los_raw = 0; fos_raw = 0;
    rst_n = 1;
    // R8 directed: rise, then R9 set wins over simultaneous clear
    los_raw = 4'b0001; cycle();
    los_raw = 4'b0000; cycle();
    los_raw = 4'b0001; clr_wr = 1; clr_data = 6'h01; cycle();
    clr_wr = 0; cycle();
    // R10 mask: flag held, no interrupt
    flag_mask = 6'h3F; fos_raw = 2'b10; cycle(); cycle(); cycle();
    flag_mask = 0; irq_sel = 1; pin_en = 4'h0; cycle(); cycle();
    // R9 clear
    clr_wr = 1; clr_data = 6'h3F; cycle(); clr_wr = 0; cycle(); cycle();
    // R1/R2 with fsync switch and fos enable, both polarities
    for (int k = 0; k < 64; k++) begin
      los_raw = k[3:0]; fos_raw = k[5:4]; fsync_sw = 1; fos_en = k[0];
      alarm_pol = k[1]; irq_sel = 0; pin_en = 4'hB; cycle();
    end
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom();
      los_raw = r[3:0]; fos_raw = r[5:4]; fsync_sw = r[6]; align_alarm = r[7];
      fos_en = r[8]; alarm_pol = r[9]; pin_en = r[13:10]; irq_sel = r[14];
      flag_mask = r[20:15]; clr_wr = r[21]; clr_data = r[27:22];
      cycle();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule